// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

The block collects up to eight interrupt requests, resolves their priority and raises one interrupt line to a processor. Software programs it through a two-address register port: a start word on the even address followed by one to three further words on the odd address. After that, the odd address holds the interrupt mask and the even address takes commands. The commands clear in-service levels, rotate priority, select which register a read returns, arm a poll, and switch special mask mode.

When the processor acknowledges, the controller marks the winning level as in service and returns an 8-bit vector. The upper five bits of that vector come from the programmed base. The lower three bits are the level. Polling is an alternative to the acknowledge input: the processor reads the even address, and that read counts as the acknowledge. Configuration bits for chaining several controllers, for buffered-bus control and for nested-mode variants are kept in registers but have no effect on behaviour.

Top module: `irq_ctrl8`

## Requirements
- R1: An even write with bit 4 set is the start word. Bit 0 = 1 means a mode word follows. Bit 1 = 0 means a link word follows. The next odd write is the vector base, then the link word (only if bit 1 was 0), then the mode word (only if bit 0 was 1). Any later odd write loads the mask.
- R2: A start word clears the mask, the in-service register and the latched requests. It also restores fixed priority (input 0 highest, input 7 lowest), selects the request register for even reads, and leaves special mask mode and poll off.
- R3: A mask bit of 1 stops the matching request from raising `int_o`. In normal mode, masking does not remove an in-service level's blocking effect.
- R4: `int_o` is high when an unmasked request has higher priority than every in-service level. An equal or lower request does not raise it.
- R5: A one-cycle `inta` pulse while `int_o` is high returns `vec_o = {base[7:3], level}` and sets that level's in-service bit. When `int_o` is low, `vec_o` carries level 7 and no state changes.
- R6: Start word bit 3 = 0 selects edge mode: a rising input is latched and kept until acknowledged. Bit 3 = 1 selects level mode: the request register follows the inputs.
- R7: With mode word bit 1 set, an acknowledge leaves the in-service register unchanged.
- R8: An even write with bits 4:3 = 00 is a command. With bit 5 set and bit 6 clear, it clears the highest-priority in-service bit. With bits 5 and 6 set, it clears the level given in bits 2:0.
- R9: In that command, bit 7 together with an end-of-interrupt makes the cleared level the lowest priority. Bits 7:5 = 110 make the level in bits 2:0 the lowest priority without clearing anything.
- R10: An odd read returns the mask. An even write with bits 4:3 = 01 and bit 1 set makes even reads return the in-service register (bit 0 = 1) or the request register (bit 0 = 0).
- R11: Such a write with bit 2 set arms a poll. The next even read returns `{pending, 0000, level}`, where level is 7 when nothing is pending. That read acts as an acknowledge and disarms the poll.
- R12: Such a write with bit 6 set loads special mask mode from bit 5. While that mode is on, in-service levels that are masked do not block lower requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address, 0 even, 1 odd |
| wr | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, valid while `rd` is high |
| irq_in | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt to processor |
| inta | input | 1 | Acknowledge pulse |
| vec_o | output | 8 | Vector, valid while `inta` is high |

## Verification
The assertions check on every cycle that `int_o` never rises without an unmasked request. They also check that a spurious acknowledge reports level 7, that a real acknowledge sets the reported level in service unless auto clearing is on, that a start word empties the mask and in-service register, and that a poll read disarms the poll. Only the bench scenarios can show the ordering effects. These are nesting, rotation after serviced and given levels, the change that special mask mode makes to blocking, branching of the setup sequence, and the edge versus level latching of requests.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int N = 8,
  parameter int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr,
  input  logic         wr,
  input  logic [7:0]   wdata,
  input  logic         rd,
  output logic [7:0]   rdata,
  input  logic [N-1:0] irq_in,
  output logic         int_o,
  input  logic         inta,
  output logic [7:0]   vec_o
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_LINK, ST_MODE} ist_t;

  ist_t ist;
  logic need_mode, single, ltim, ris, smm, poll;
  logic [7:0] base, link;
  logic [4:0] mode;
  logic [N-1:0] imr, isr, irr_q, irq_d;
  logic [LW-1:0] lo;

  function automatic logic [LW:0] pick(input logic [N-1:0] v, input logic [LW-1:0] l);
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[LW'(l + LW'(1) + LW'(i))]) pick = {1'b1, LW'(i)};
  endfunction

  wire we = wr & ~addr;
  wire wo = wr & addr;
  wire is_start = we & wdata[4];
  wire is_cmd = we & ~wdata[4] & ~wdata[3];
  wire is_sel = we & ~wdata[4] & wdata[3];
  wire aeoi = mode[1];

  wire [N-1:0] irr_v = ltim ? irq_in : irr_q;
  wire [N-1:0] req = irr_v & ~imr;
  wire [N-1:0] blk = smm ? (isr & ~imr) : isr;
  wire [LW:0] rq_p = pick(req, lo);
  wire [LW:0] bk_p = pick(blk, lo);
  wire [LW:0] hi_p = pick(isr, lo);

  assign int_o = rq_p[LW] & (~bk_p[LW] | (rq_p[LW-1:0] < bk_p[LW-1:0]));
  wire [LW-1:0] win = int_o ? LW'(lo + LW'(1) + rq_p[LW-1:0]) : LW'(N - 1);
  wire [LW-1:0] hi_lvl = LW'(lo + LW'(1) + hi_p[LW-1:0]);
  assign vec_o = {base[7:LW], win};

  wire poll_rd = rd & ~addr & poll;
  wire take = (inta | poll_rd) & int_o;
  wire [N-1:0] take_m = take ? (N'(1) << win) : '0;
  wire [LW-1:0] eoi_lvl = wdata[6] ? wdata[LW-1:0] : hi_lvl;
  wire eoi_do = is_cmd & wdata[5] & (wdata[6] | hi_p[LW]);
  wire [N-1:0] eoi_m = eoi_do ? (N'(1) << eoi_lvl) : '0;
  wire rot_set = is_cmd & wdata[7] & (eoi_do | (wdata[6] & ~wdata[5]));

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr) rdata = 8'(imr);
      else if (poll) rdata = {int_o, 4'b0000, 3'(win)};
      else if (ris) rdata = 8'(isr);
      else rdata = 8'(irr_v);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist <= ST_RUN;
      {need_mode, single, ltim, ris, smm, poll} <= '0;
      base <= '0; link <= '0; mode <= '0;
      imr <= '0; isr <= '0; irr_q <= '0; irq_d <= '0;
      lo <= LW'(N - 1);
    end else begin
      irq_d <= irq_in;
      if (is_start) begin
        need_mode <= wdata[0];
        single <= wdata[1];
        ltim <= wdata[3];
        mode <= '0;
        imr <= '0;
        isr <= '0;
        irr_q <= '0;
        lo <= LW'(N - 1);
        ris <= 1'b0;
        smm <= 1'b0;
        poll <= 1'b0;
        ist <= ST_BASE;
      end else begin
        isr <= (isr | (aeoi ? '0 : take_m)) & ~eoi_m;
        irr_q <= (irr_q & ~take_m) | (irq_in & ~irq_d);
        if (rot_set) lo <= eoi_do ? eoi_lvl : wdata[LW-1:0];
        if (poll_rd) poll <= 1'b0;
        if (is_sel) begin
          if (wdata[1]) ris <= wdata[0];
          if (wdata[2]) poll <= 1'b1;
          if (wdata[6]) smm <= wdata[5];
        end
        if (wo) begin
          case (ist)
            ST_BASE: begin
              base <= wdata;
              ist <= !single ? ST_LINK : (need_mode ? ST_MODE : ST_RUN);
            end
            ST_LINK: begin
              link <= wdata;
              ist <= need_mode ? ST_MODE : ST_RUN;
            end
            ST_MODE: begin
              mode <= wdata[4:0];
              ist <= ST_RUN;
            end
            default: imr <= wdata[N-1:0];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr,
  input logic [7:0] wdata,
  input logic       rd,
  input logic       inta,
  input logic       int_o,
  input logic [7:0] vec_o,
  input logic [7:0] irr_v,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [4:0] mode,
  input logic       poll
);
  AST_INT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr_v & ~imr) != 8'h00)); // R4
  AST_SPURIOUS_LVL7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_o) |-> (vec_o[2:0] == 3'd7)); // R5
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && !mode[1] && !wr) |=> isr[$past(vec_o[2:0])]); // R5
  AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && mode[1] && !wr) |=> (isr == $past(isr))); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && wdata[4]) |=> (imr == 8'h00 && isr == 8'h00)); // R2
  AST_POLL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !addr && poll && !wr) |=> !poll); // R11
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
  .inta(inta), .int_o(int_o), .vec_o(vec_o), .irr_v(irr_v), .imr(imr),
  .isr(isr), .mode(mode), .poll(poll)
);

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
  logic clk = 0, rst_n = 0, addr = 0, wr = 0, rd = 0, inta = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [7:0] rdata, vec_o;
  logic int_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_ctrl8 dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
    .rd(rd), .rdata(rdata), .irq_in(irq_in), .int_o(int_o), .inta(inta), .vec_o(vec_o));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1; #1 v = vec_o;
    @(negedge clk); inta = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic init(input logic lvl, input logic [7:0] m);
    set_irq(8'h00);
    wreg(0, lvl ? 8'h1B : 8'h13);
    wreg(1, 8'h40);
    wreg(1, m);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R2 reset int_o", {7'b0, int_o}, 8'h00);
    rreg(1, d); chk("R10 reset mask", d, 8'h00);
    rreg(0, d); chk("R10 reset request", d, 8'h00);
  endtask

  task automatic t_setup;
    logic [7:0] d;
    wreg(0, 8'h12); wreg(1, 8'h40); wreg(1, 8'h3C);
    rreg(1, d); chk("R1 single no mode word", d, 8'h3C);
    wreg(1, 8'hFF);
    wreg(0, 8'h11); wreg(1, 8'h48);
    rreg(1, d); chk("R2 mask cleared", d, 8'h00);
    wreg(1, 8'h04); wreg(1, 8'h01); wreg(1, 8'h0F);
    rreg(1, d); chk("R1 linked with mode word", d, 8'h0F);
    wreg(1, 8'h00);
    ack(d); chk("R5 spurious vector", d, 8'h4F);
  endtask

  task automatic t_nest;
    logic [7:0] d;
    init(0, 8'h01);
    wreg(1, 8'h02);
    set_irq(8'h0A);
    chk("R4 int with request", {7'b0, int_o}, 8'h01);
    ack(d); chk("R3 masked skipped", d, 8'h43);
    wreg(0, 8'h0B); rreg(0, d); chk("R10 in-service read", d, 8'h08);
    wreg(1, 8'h00);
    chk("R4 higher nests", {7'b0, int_o}, 8'h01);
    ack(d); chk("R5 vector", d, 8'h41);
    rreg(0, d); chk("R5 isr set", d, 8'h0A);
    chk("R4 no equal/lower", {7'b0, int_o}, 8'h00);
    wreg(0, 8'h20); rreg(0, d); chk("R8 nonspecific eoi", d, 8'h08);
    wreg(0, 8'h63); rreg(0, d); chk("R8 specific eoi", d, 8'h00);
    set_irq(8'h00);
    ack(d); chk("R5 spurious", d, 8'h47);
    rreg(0, d); chk("R5 spurious no change", d, 8'h00);
  endtask

  task automatic t_trigger;
    logic [7:0] d;
    init(0, 8'h01);
    set_irq(8'h04); set_irq(8'h00);
    rreg(0, d); chk("R6 edge held", d, 8'h04);
    ack(d); chk("R6 edge vector", d, 8'h42);
    rreg(0, d); chk("R6 edge cleared by ack", d, 8'h00);
    init(1, 8'h01);
    set_irq(8'h04);
    rreg(0, d); chk("R6 level follows high", d, 8'h04);
    set_irq(8'h00);
    rreg(0, d); chk("R6 level follows low", d, 8'h00);
    chk("R6 level int low", {7'b0, int_o}, 8'h00);
  endtask

  task automatic t_auto;
    logic [7:0] d;
    init(0, 8'h03);
    set_irq(8'h20);
    ack(d); chk("R7 vector", d, 8'h45);
    wreg(0, 8'h0B); rreg(0, d); chk("R7 isr untouched", d, 8'h00);
    chk("R7 int low", {7'b0, int_o}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_rotate;
    logic [7:0] d;
    init(0, 8'h01);
    set_irq(8'h03);
    ack(d); chk("R4 fixed order", d, 8'h40);
    wreg(0, 8'hA0);
    set_irq(8'h02); set_irq(8'h03);
    ack(d); chk("R9 rotate on eoi", d, 8'h41);
    wreg(0, 8'hC4);
    set_irq(8'h23);
    ack(d); chk("R9 set lowest", d, 8'h45);
    wreg(0, 8'hE5);
    ack(d); chk("R9 specific rotate", d, 8'h40);
    set_irq(8'h00);
    wreg(0, 8'h13); wreg(1, 8'h40); wreg(1, 8'h01);
    set_irq(8'h81);
    ack(d); chk("R2 priority restored", d, 8'h40);
    set_irq(8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    init(0, 8'h01);
    set_irq(8'h40);
    wreg(0, 8'h0C); rreg(0, d); chk("R11 poll word", d, 8'h86);
    wreg(0, 8'h0B); rreg(0, d); chk("R11 poll acknowledged", d, 8'h40);
    wreg(0, 8'h0C); rreg(0, d); chk("R11 poll idle", d, 8'h07);
    rreg(0, d); chk("R11 poll disarmed", d, 8'h40);
    set_irq(8'h00);
  endtask

  task automatic t_smm;
    logic [7:0] d;
    init(0, 8'h01);
    set_irq(8'h08);
    ack(d); chk("R12 first ack", d, 8'h43);
    set_irq(8'h48);
    chk("R12 blocked", {7'b0, int_o}, 8'h00);
    wreg(1, 8'h08);
    chk("R3 mask keeps block", {7'b0, int_o}, 8'h00);
    wreg(0, 8'h68);
    chk("R12 mode on", {7'b0, int_o}, 8'h01);
    wreg(0, 8'h48);
    chk("R12 mode off", {7'b0, int_o}, 8'h00);
    wreg(0, 8'h68);
    ack(d); chk("R12 lower served", d, 8'h46);
    set_irq(8'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_nest();
    t_trigger();
    t_auto();
    t_rotate();
    t_poll();
    t_smm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule